// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block watches the live active/inactive state of a set of event codes, such as keys held down or general-purpose inputs at a given level. It raises a reset output only when a chosen combination of those codes has been held together for a selectable time. There are two independent channels. Channel A has three trigger slots and channel B has two. Each slot names one event code and the level that code must show. A slot left at zero takes no part in the decision.

Once every used slot of a channel matches in the same cycle, a per-channel hold counter starts. When the counter reaches the hold count picked by a shared 3-bit selector from a parameter table, that channel's reset output asserts. The output stays asserted while the combination is held. Each output has its own polarity bit. Channel A can also pass an external active-low reset pin straight through to its output.

Top module: `key_combo_rst`

## Requirements
- R1: A trigger slot is 8 bits wide. Bit 7 is the required level and bits 6:0 are the event code. A used slot matches when `evActive[code]` equals the level bit.
- R2: A slot whose 8 bits are all zero is unused. The state of any event it might name has no effect on the output.
- R3: A channel whose slots are all zero never asserts its reset from the key path.
- R4: A channel's combination holds only in a cycle where every used slot of that channel matches.
- R5: `holdSel` picks hold count H from `HOLD_TABLE`, where code k sits at bits [k*CNT_W +: CNT_W]. The defaults for codes 0 to 7 are 1, 2, 3, 4, 6, 8, 12 and 16. The reset asserts after H consecutive rising edges at which the combination held. A table entry of 0 acts as 1.
- R6: If the combination breaks before H edges have passed, the hold count returns to zero. A later hold needs the full H edges again.
- R7: The key-path reset stays asserted while the combination keeps holding. It deasserts after the first rising edge at which the combination no longer holds.
- R8: `polA` and `polB` set the active level of their outputs (1 = active high, 0 = active low). While reset is applied and right after it, both outputs sit at their inactive level.
- R9: While `passEn` is 1, a low level on `extRstN` asserts `rstAOut` in the same cycle without waiting for a clock. `rstBOut` is not affected by the pin. While `passEn` is 0, `extRstN` has no effect.
- R10: Channel B uses its own two slots with the same matching and timing rules and the shared `holdSel`. It is independent of channel A's slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the block |
| evActive | input | 128 | Current active state, one bit per event code |
| trigSlotsA | input | 24 | Channel A slots, slot s at bits [8s+7:8s] |
| trigSlotsB | input | 16 | Channel B slots, slot s at bits [8s+7:8s] |
| holdSel | input | 3 | Hold-time selector into the hold table |
| polA | input | 1 | Active level of rstAOut |
| polB | input | 1 | Active level of rstBOut |
| passEn | input | 1 | Enables pass-through of extRstN to rstAOut |
| extRstN | input | 1 | External active-low reset pin |
| rstAOut | output | 1 | Channel A reset output |
| rstBOut | output | 1 | Channel B reset output |

## Verification
Two functions can fall in the same cycle. One is a hold that completes on channel A. The other is the pass-through pin, which asserts the same output from a separate path. The bench first lets the key combination fire. It then pulls `extRstN` low with pass-through enabled and breaks the combination in that same cycle. After the next edge the output must still read asserted through the pin while the key path has dropped. It must read inactive once the pin is released. A separate case pulls the pin low while pass-through is disabled and expects no change.

// File: rtl/krg_pkg.sv
package krg_pkg;
  localparam int SLOT_W = 8;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic fire;
  } krg_strobe_t;
endpackage

// File: rtl/krg_ctrl.sv
module krg_ctrl
  import krg_pkg::*;
#(
  parameter int NUM_SLOTS = 3,
  parameter int CODE_W    = 7,
  parameter int CNT_W     = 16,
  localparam int NUM_CODES = 2 ** CODE_W,
  localparam int SW        = CODE_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CODES-1:0]   evActive,
  input  logic [NUM_SLOTS*SW-1:0] slotCfg,
  input  logic [CNT_W-1:0]       holdCnt,
  input  logic [CNT_W-1:0]       curCnt,
  output krg_strobe_t            strb
);
  logic [NUM_SLOTS-1:0] slotUsed;
  logic [NUM_SLOTS-1:0] slotHit;
  logic                 comboMatch;
  logic [CNT_W-1:0]     holdEff;
  logic [CNT_W:0]       nextCnt;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SW-1:0] slotVal;
    assign slotVal    = slotCfg[s*SW +: SW];
    assign slotUsed[s] = |slotVal;
    assign slotHit[s]  = (evActive[slotVal[CODE_W-1:0]] == slotVal[CODE_W]);
  end

  always_comb begin
    comboMatch = (|slotUsed) && (&(slotHit | ~slotUsed));
    holdEff    = (holdCnt == '0) ? CNT_W'(1) : holdCnt;
    nextCnt    = {1'b0, curCnt} + (CNT_W + 1)'(1);
    strb.clrCnt = !comboMatch;
    strb.incCnt = comboMatch && (curCnt < holdEff);
    strb.fire   = comboMatch && (nextCnt >= {1'b0, holdEff});
  end

  // R3: with no used slot, the control must never request a fire
  a_r3_no_slot_no_fire: assert property (@(posedge clk) disable iff (!rstN)
    (slotCfg == '0) |-> !strb.fire);

  // R4: a fire request only comes while the combination holds
  a_r4_fire_needs_match: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |-> !strb.clrCnt);
endmodule

// File: rtl/krg_dp.sv
module krg_dp
  import krg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  krg_strobe_t      strb,
  output logic [CNT_W-1:0] cnt,
  output logic             fired
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (strb.clrCnt)      cnt <= '0;
      else if (strb.incCnt) cnt <= cnt + CNT_W'(1);
      fired <= strb.fire;
    end
  end

  // R6: a broken combination leaves the hold count at zero
  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cnt == '0));

  // R7: a broken combination drops the key-path reset on the next edge
  a_r7_drop_next: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> !fired);

  // R5: the key-path reset follows the fire request one edge later
  a_r5_fire_follow: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> fired);
endmodule

// File: rtl/key_combo_rst.sv
module key_combo_rst
  import krg_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 3,
  parameter logic [(2**SEL_W)*CNT_W-1:0] HOLD_TABLE =
    {16'd16, 16'd12, 16'd8, 16'd6, 16'd4, 16'd3, 16'd2, 16'd1},
  localparam int NUM_CODES = 2 ** CODE_W,
  localparam int SW        = CODE_W + 1,
  localparam int SLOTS_A   = 3,
  localparam int SLOTS_B   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CODES-1:0]    evActive,
  input  logic [SLOTS_A*SW-1:0]   trigSlotsA,
  input  logic [SLOTS_B*SW-1:0]   trigSlotsB,
  input  logic [SEL_W-1:0]        holdSel,
  input  logic                    polA,
  input  logic                    polB,
  input  logic                    passEn,
  input  logic                    extRstN,
  output logic                    rstAOut,
  output logic                    rstBOut
);
  logic [CNT_W-1:0] holdCnt;
  krg_strobe_t      strbA, strbB;
  logic [CNT_W-1:0] cntA, cntB;
  logic             firedA, firedB;
  logic             assertA;

  assign holdCnt = HOLD_TABLE[int'(holdSel)*CNT_W +: CNT_W];

  krg_ctrl #(.NUM_SLOTS(SLOTS_A), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrlA (
    .clk(clk), .rstN(rstN), .evActive(evActive), .slotCfg(trigSlotsA),
    .holdCnt(holdCnt), .curCnt(cntA), .strb(strbA));

  krg_dp #(.CNT_W(CNT_W)) u_dpA (
    .clk(clk), .rstN(rstN), .strb(strbA), .cnt(cntA), .fired(firedA));

  krg_ctrl #(.NUM_SLOTS(SLOTS_B), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrlB (
    .clk(clk), .rstN(rstN), .evActive(evActive), .slotCfg(trigSlotsB),
    .holdCnt(holdCnt), .curCnt(cntB), .strb(strbB));

  krg_dp #(.CNT_W(CNT_W)) u_dpB (
    .clk(clk), .rstN(rstN), .strb(strbB), .cnt(cntB), .fired(firedB));

  assign assertA = firedA | (passEn & ~extRstN);
  assign rstAOut = polA ? assertA : ~assertA;
  assign rstBOut = polB ? firedB : ~firedB;

  // R9: pin low with pass-through enabled forces channel A active
  a_r9_pass_forces: assert property (@(posedge clk) disable iff (!rstN)
    (passEn && !extRstN) |-> (rstAOut == polA));

  // R3: an all-zero channel A stays quiet on the key path
  a_r3_idle_channel: assert property (@(posedge clk) disable iff (!rstN)
    (trigSlotsA == '0) |=> !firedA);
endmodule

// File: tb/tb_key_combo_rst.sv
module tb_key_combo_rst;
  logic         clk = 1'b0;
  logic         rstN;
  logic [127:0] ev;
  logic [23:0]  slotsA;
  logic [15:0]  slotsB;
  logic [2:0]   holdSel;
  logic         polA, polB, passEn, extRstN;
  logic         rstAOut, rstBOut;

  int checks = 0;
  int errors = 0;
  localparam int HT[8] = '{1, 2, 3, 4, 6, 8, 12, 16};

  always #4 clk = ~clk;

  key_combo_rst dut (
    .clk(clk), .rstN(rstN), .evActive(ev), .trigSlotsA(slotsA),
    .trigSlotsB(slotsB), .holdSel(holdSel), .polA(polA), .polB(polB),
    .passEn(passEn), .extRstN(extRstN), .rstAOut(rstAOut), .rstBOut(rstBOut));

  function automatic logic lvl(input logic act, input logic pol);
    return pol ? act : ~act;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // slot A codes: 5 level 1, 9 level 0, 70 level 1
  function automatic logic [23:0] buildA(input int mask);
    logic [23:0] v = '0;
    if (mask[0]) v[7:0]   = {1'b1, 7'd5};
    if (mask[1]) v[15:8]  = {1'b0, 7'd9};
    if (mask[2]) v[23:16] = {1'b1, 7'd70};
    return v;
  endfunction

  task automatic satisfyA();
    ev[5] = 1'b1; ev[9] = 1'b0; ev[70] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; ev = '0; slotsA = '0; slotsB = '0; holdSel = 3'd0;
    polA = 1'b1; polB = 1'b1; passEn = 1'b0; extRstN = 1'b1;
    repeat (3) tick();
    chk("R8 reset A inactive", rstAOut, 1'b0);
    chk("R8 reset B inactive", rstBOut, 1'b0);
    rstN = 1'b1;
    tick();
    chk("R8 after reset A", rstAOut, 1'b0);

    // R1 R2 R3 R4: sweep of every used-slot mask with H = 1
    holdSel = 3'd0;
    for (int m = 0; m < 8; m++) begin
      slotsA = buildA(m);
      satisfyA();
      tick();
      chk((m == 0) ? "R3 all zero never fires" : "R1 R4 all used match",
          rstAOut, (m != 0));
      for (int j = 0; j < 3; j++) begin
        int code;
        code = (j == 0) ? 5 : (j == 1) ? 9 : 70;
        ev[code] = ~ev[code];
        tick();
        if (m[j]) chk("R4 one used slot breaks", rstAOut, 1'b0);
        else      chk("R2 unused slot ignored", rstAOut, (m != 0));
        ev[code] = ~ev[code];
        tick();
        chk("R1 restored match", rstAOut, (m != 0));
      end
    end
    slotsA = '0; ev = '0;
    tick();

    // R5 R6 R7: hold-time sweep over every selector code
    slotsA = buildA(1);
    for (int t = 0; t < 8; t++) begin
      int h;
      h = HT[t];
      holdSel = 3'(t);
      ev[5] = 1'b0;
      tick();
      ev[5] = 1'b1;
      for (int n = 1; n <= h + 2; n++) begin
        tick();
        chk("R5 hold count", rstAOut, (n >= h));
      end
      ev[5] = 1'b0;
      tick();
      chk("R7 deassert one edge after break", rstAOut, 1'b0);
      if (h >= 2) begin
        ev[5] = 1'b1;
        for (int n = 1; n < h; n++) begin tick(); chk("R6 partial hold", rstAOut, 1'b0); end
        ev[5] = 1'b0;
        tick();
        chk("R6 break before expiry", rstAOut, 1'b0);
        ev[5] = 1'b1;
        for (int n = 1; n < h; n++) begin tick(); chk("R6 full hold needed again", rstAOut, 1'b0); end
        tick();
        chk("R6 fires after full hold", rstAOut, 1'b1);
        ev[5] = 1'b0;
        tick();
      end
    end

    // R8: active-low polarity on A
    polA = 1'b0; holdSel = 3'd1; ev[5] = 1'b1;
    tick();
    chk("R8 low polarity idle", rstAOut, lvl(1'b0, 1'b0));
    tick();
    chk("R8 low polarity active", rstAOut, lvl(1'b1, 1'b0));
    ev[5] = 1'b0; tick(); polA = 1'b1;
    #1 chk("R8 high polarity idle", rstAOut, 1'b0);

    // R10: channel B independent, H = 3
    slotsA = '0; holdSel = 3'd2;
    slotsB = {1'b0, 7'd33, 1'b1, 7'd100};
    ev = '0; ev[33] = 1'b0; ev[100] = 1'b1;
    for (int n = 1; n <= 4; n++) begin
      tick();
      chk("R10 channel B hold", rstBOut, (n >= 3));
      chk("R10 channel A untouched", rstAOut, 1'b0);
    end
    ev[33] = 1'b1;
    tick();
    chk("R10 channel B second slot breaks", rstBOut, 1'b0);
    polB = 1'b0;
    #1 chk("R8 B low polarity idle", rstBOut, 1'b1);
    polB = 1'b1; slotsB = '0; ev = '0;
    tick();

    // R9: pass-through
    extRstN = 1'b0;
    #1 chk("R9 pin ignored when disabled", rstAOut, 1'b0);
    passEn = 1'b1;
    #1 chk("R9 pin passes through", rstAOut, 1'b1);
    chk("R9 B unaffected", rstBOut, 1'b0);
    polA = 1'b0;
    #1 chk("R9 pass with low polarity", rstAOut, 1'b0);
    polA = 1'b1; extRstN = 1'b1;
    #1 chk("R9 pin released", rstAOut, 1'b0);

    // R9 R7: key fire and pin in the same cycle
    slotsA = buildA(1); holdSel = 3'd0; ev[5] = 1'b1;
    tick();
    chk("R7 key path active", rstAOut, 1'b1);
    extRstN = 1'b0; ev[5] = 1'b0;
    tick();
    chk("R9 pin holds while key path drops", rstAOut, 1'b1);
    extRstN = 1'b1;
    #1 chk("R7 inactive after both release", rstAOut, 1'b0);
    passEn = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule